// File: doc/BRIEF.md
# Block Data FIFO Transfer Engine

This block carries the data phase of a block transfer between a processor-side register port and a byte-wide card data stream. For reads from the card, bytes arrive over a valid/ready stream into a 32-byte circular receive queue. The processor drains that queue with accesses of 1, 2 or 4 bytes. For writes to the card, the processor fills a transmit queue with accesses of the same widths, and the engine hands those bytes to the card one per cycle over a second valid/ready stream.

A data phase starts with a one-cycle start pulse. On that pulse the engine captures the block length, the block count and the transfer direction. It then counts down the bytes still owed. While the phase runs it raises service events so the processor knows to read or write the queues. When the count runs out it flags completion in two sticky status bits and in two acknowledgeable event bits. A clock-stop pulse abandons the phase at once.

A partial-buffer command lets software close off a short transmit burst. It discards whatever is queued and moves the transmit pointer to the other half of a 64-byte store.

Top module: `blk_xfer_engine`

## Requirements
- R1: A start pulse loads the remaining-byte count with block length (12 bits) times block count (16 bits), clears both transmit and receive queues, and asserts busy from the next cycle on.
- R2: The receive stream is ready only while busy, in read direction, with fewer than 32 bytes held and a nonzero remaining count; the queue never holds more than 32 bytes.
- R3: Each byte accepted from the card lowers the remaining count by one and sets the receive-service event on the next cycle.
- R4: A receive-port read of N bytes returns the oldest byte in bits 8N-1..8N-8, the next one in the lane below, and so on; lanes with no byte read as zero; the read pops only the bytes it returned and clears the receive-service event (a byte arriving in the same cycle sets it again).
- R5: A transmit-port write of N bytes queues its highest lane first, working down; once 32 bytes are queued, further bytes are dropped; the write clears the transmit-service event.
- R6: In write direction, queued bytes leave on the card stream in the order they were queued, one per accepted handshake, while the remaining count is nonzero; the transmit-service event is set when the queue is empty while bytes are still owed.
- R7: When the remaining count is zero during a phase, busy drops on the next edge and data-done is set in both status and events; in write direction program-done is set in both as well.
- R8: The partial-buffer command discards all queued transmit bytes and switches writing to the other 32-byte half of the transmit store; only bytes written afterwards are sent.
- R9: A clock-stop pulse clears busy on the next edge without setting any completion flag.
- R10: The direction (1 = toward the card) is captured at start and held for the whole phase, regardless of later changes on the direction input.
- R11: Access width code: 0 means 1 byte, 1 means 2 bytes, 2 and 3 mean 4 bytes.
- R12: The completion events clear on an acknowledge bit (bit 0 data-done, bit 1 program-done); the completion status bits clear only at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle data-phase start |
| dir_wr_i | input | 1 | Direction for the next start, 1 = toward the card |
| blk_len_i | input | 12 | Bytes per block |
| blk_cnt_i | input | 16 | Number of blocks |
| clk_stop_i | input | 1 | Abort pulse (card clock stopped) |
| acc_size_i | input | 2 | Processor access width code |
| rd_pop_i | input | 1 | Receive-port read strobe |
| rd_data_o | output | 32 | Packed receive data for the current access width |
| wr_push_i | input | 1 | Transmit-port write strobe |
| wr_data_i | input | 32 | Transmit data, packed highest lane first |
| flush_i | input | 1 | Partial-buffer command |
| ev_ack_i | input | 2 | Completion event acknowledge, write-1-to-clear |
| card_rx_valid_i | input | 1 | Card byte available |
| card_rx_data_i | input | 8 | Card byte |
| card_rx_ready_o | output | 1 | Engine accepts a card byte |
| card_tx_valid_o | output | 1 | Engine offers a byte to the card |
| card_tx_data_o | output | 8 | Byte offered to the card |
| card_tx_ready_i | input | 1 | Card takes the offered byte |
| busy_o | output | 1 | Data phase in progress |
| remain_o | output | 28 | Bytes still owed in the phase |
| ev_rx_svc_o | output | 1 | Receive-service event |
| ev_tx_svc_o | output | 1 | Transmit-service event |
| ev_data_done_o | output | 1 | Data-done event |
| ev_prog_done_o | output | 1 | Program-done event |
| st_data_done_o | output | 1 | Data-done status |
| st_prog_done_o | output | 1 | Program-done status |

## Verification
The embedded properties assume that a start pulse and a clock-stop pulse never fall in the same cycle. They also assume that the partial-buffer command is never issued in the same cycle as a transmit write. The directed tests keep to both rules by giving each command its own cycle. They also raise the card-side valid and ready lines only in the direction of the current phase, so the queue bounds and the countdown properties are exercised under legal traffic alone.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  typedef enum logic [1:0] {
    ACC_ONE      = 2'd0,
    ACC_TWO      = 2'd1,
    ACC_FOUR     = 2'd2,
    ACC_FOUR_ALT = 2'd3
  } acc_size_e;

  // number of bytes moved by one processor access (R11)
  function automatic logic [2:0] acc_bytes(input acc_size_e s);
    case (s)
      ACC_ONE: return 3'd1;
      ACC_TWO: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/blkx_rx_fifo.sv
module blkx_rx_fifo #(
  parameter  int DEPTH = 32,
  parameter  int LANES = 4,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1,
  localparam int NW    = $clog2(LANES + 1),
  localparam int DW    = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    push_byte_i,
  input  logic          pop_i,
  input  logic [NW-1:0] pop_n_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] cnt_o
);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] take;

  // oldest byte lands in the highest lane of the access
  always_comb begin
    take      = (cnt_q < CW'(pop_n_i)) ? cnt_q : CW'(pop_n_i);
    rd_data_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(pop_n_i) && k < int'(cnt_q)) begin
        rd_data_o[(int'(pop_n_i) - 1 - k) * 8 +: 8] = mem_q[rd_ptr_q + PW'(k)];
      end
    end
  end

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (pop_i) begin
      rd_ptr_d = rd_ptr_q + take[PW-1:0];
      cnt_d    = cnt_q - take;
    end
    if (push_i) begin
      cnt_d = cnt_d + 1'b1;
    end
    if (clr_i) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem_q[rd_ptr_q + cnt_q[PW-1:0]] <= push_byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: occupancy never exceeds the queue depth
  p_rx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R2: a card byte is only taken while room remains
  p_rx_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CW'(DEPTH)));

endmodule

// File: rtl/blkx_tx_fifo.sv
module blkx_tx_fifo #(
  parameter  int HALF  = 32,
  parameter  int LANES = 4,
  localparam int PW    = $clog2(HALF),
  localparam int CW    = PW + 1,
  localparam int NW    = $clog2(LANES + 1),
  localparam int DW    = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [NW-1:0] push_n_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [7:0]    head_o,
  output logic [CW-1:0] cnt_o
);

  logic [7:0]    mem_q [2*HALF];
  logic [PW:0]   ptr_q, ptr_d;   // top bit picks the half
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] room, nput;

  always_comb begin
    room = CW'(HALF) - cnt_q;
    nput = (room < CW'(push_n_i)) ? room : CW'(push_n_i);
  end

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (pop_i) begin
      ptr_d[PW-1:0] = ptr_q[PW-1:0] + 1'b1;
      cnt_d         = cnt_d - 1'b1;
    end
    if (push_i) begin
      cnt_d = cnt_d + nput;
    end
    if (flush_i) begin
      ptr_d[PW] = ~ptr_q[PW];
    end
    if (flush_i || clr_i) begin
      cnt_d = '0;
    end
  end

  // highest lane of the access is queued first
  always_ff @(posedge clk) begin
    if (push_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (CW'(k) < nput) begin
          mem_q[{ptr_q[PW], ptr_q[PW-1:0] + cnt_q[PW-1:0] + PW'(k)}] <=
            push_data_i[(int'(push_n_i) - 1 - k) * 8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o = mem_q[ptr_q];
  assign cnt_o  = cnt_q;

  // R5: the queue holds at most one half of the store
  p_tx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(HALF));

  // R6: a byte only leaves a non-empty queue
  p_tx_pop_filled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/blkx_xfer_ctrl.sv
module blkx_xfer_ctrl #(
  parameter  int LEN_W = 12,
  parameter  int NUM_W = 16,
  localparam int RW    = LEN_W + NUM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [NUM_W-1:0] blk_num_i,
  input  logic             stop_i,
  input  logic             byte_done_i,
  input  logic             rx_got_i,
  input  logic             rx_read_i,
  input  logic             tx_write_i,
  input  logic             tx_empty_i,
  input  logic [1:0]       ev_ack_i,
  output logic             busy_o,
  output logic             dir_o,
  output logic [RW-1:0]    remain_o,
  output logic             ev_rx_svc_o,
  output logic             ev_tx_svc_o,
  output logic             ev_data_done_o,
  output logic             ev_prog_done_o,
  output logic             st_data_done_o,
  output logic             st_prog_done_o
);

  logic          busy_q, busy_d;
  logic          dir_q, dir_d;
  logic [RW-1:0] remain_q, remain_d;
  logic          remain_en;
  logic          rxsvc_q, rxsvc_d, txsvc_q, txsvc_d;
  logic          evdd_q, evdd_d, evpd_q, evpd_d;
  logic          stdd_q, stdd_d, stpd_q, stpd_d;
  logic          owed, finish;

  assign owed   = (remain_q != '0);
  assign finish = busy_q && !owed;

  always_comb begin
    busy_d    = busy_q;
    dir_d     = dir_q;
    remain_d  = remain_q;
    remain_en = 1'b0;
    stdd_d    = stdd_q;
    stpd_d    = stpd_q;
    evdd_d    = evdd_q && !ev_ack_i[0];
    evpd_d    = evpd_q && !ev_ack_i[1];

    rxsvc_d = rxsvc_q;
    if (rx_read_i) rxsvc_d = 1'b0;
    if (rx_got_i)  rxsvc_d = 1'b1;

    txsvc_d = txsvc_q;
    if (busy_q && dir_q && owed && tx_empty_i) txsvc_d = 1'b1;
    if (tx_write_i) txsvc_d = 1'b0;

    if (busy_q && byte_done_i && owed) begin
      remain_d  = remain_q - 1'b1;
      remain_en = 1'b1;
    end

    if (finish) begin
      busy_d = 1'b0;
      stdd_d = 1'b1;
      evdd_d = 1'b1;
      if (dir_q) begin
        stpd_d = 1'b1;
        evpd_d = 1'b1;
      end
    end

    if (start_i) begin
      busy_d    = 1'b1;
      dir_d     = dir_i;
      remain_d  = RW'(blk_len_i) * RW'(blk_num_i);
      remain_en = 1'b1;
      stdd_d    = 1'b0;
      stpd_d    = 1'b0;
    end

    if (stop_i) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dir_q    <= 1'b0;
      remain_q <= '0;
      rxsvc_q  <= 1'b0;
      txsvc_q  <= 1'b0;
      evdd_q   <= 1'b0;
      evpd_q   <= 1'b0;
      stdd_q   <= 1'b0;
      stpd_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      dir_q   <= dir_d;
      rxsvc_q <= rxsvc_d;
      txsvc_q <= txsvc_d;
      evdd_q  <= evdd_d;
      evpd_q  <= evpd_d;
      stdd_q  <= stdd_d;
      stpd_q  <= stpd_d;
      if (remain_en) begin
        remain_q <= remain_d;
      end
    end
  end

  assign busy_o         = busy_q;
  assign dir_o          = dir_q;
  assign remain_o       = remain_q;
  assign ev_rx_svc_o    = rxsvc_q;
  assign ev_tx_svc_o    = txsvc_q;
  assign ev_data_done_o = evdd_q;
  assign ev_prog_done_o = evpd_q;
  assign st_data_done_o = stdd_q;
  assign st_prog_done_o = stpd_q;

  // R3: every moved byte lowers the count by exactly one
  p_remain_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && byte_done_i && owed && !start_i && !stop_i)
      |=> (remain_q == $past(remain_q) - RW'(1)));

  // R7: an exhausted count ends the phase with data-done
  p_done_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !start_i && !stop_i) |=> (!busy_q && stdd_q && evdd_q));

  // R7: program-done only appears for a phase toward the card
  p_prog_only_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stpd_q) |-> dir_q);

  // R9: clock stop aborts on the next edge
  p_stop_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !busy_q);

  // R10: direction holds while no new start arrives
  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i) |=> $stable(dir_q));

endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine #(
  parameter  int RX_DEPTH = 32,
  parameter  int TX_HALF  = 32,
  parameter  int LANES    = 4,
  parameter  int LEN_W    = 12,
  parameter  int NUM_W    = 16,
  localparam int DW       = LANES * 8,
  localparam int RW       = LEN_W + NUM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [NUM_W-1:0] blk_cnt_i,
  input  logic             clk_stop_i,
  input  logic [1:0]       acc_size_i,
  input  logic             rd_pop_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             wr_push_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             flush_i,
  input  logic [1:0]       ev_ack_i,
  input  logic             card_rx_valid_i,
  input  logic [7:0]       card_rx_data_i,
  output logic             card_rx_ready_o,
  output logic             card_tx_valid_o,
  output logic [7:0]       card_tx_data_o,
  input  logic             card_tx_ready_i,
  output logic             busy_o,
  output logic [RW-1:0]    remain_o,
  output logic             ev_rx_svc_o,
  output logic             ev_tx_svc_o,
  output logic             ev_data_done_o,
  output logic             ev_prog_done_o,
  output logic             st_data_done_o,
  output logic             st_prog_done_o
);

  import blkx_pkg::*;

  localparam int NW  = $clog2(LANES + 1);
  localparam int RCW = $clog2(RX_DEPTH) + 1;
  localparam int TCW = $clog2(TX_HALF) + 1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [NW-1:0]  acc_n;
  logic [RCW-1:0] rx_cnt;
  logic [TCW-1:0] tx_cnt;
  logic [7:0]     tx_head;
  logic           busy, dir_q, owed;
  logic           rx_push, tx_pop, byte_done;

  assign acc_n = NW'(acc_bytes(acc_size_e'(acc_size_i)));
  assign owed  = (remain_o != '0);

  assign card_rx_ready_o = busy && !dir_q && owed && (rx_cnt < RCW'(RX_DEPTH));
  assign rx_push         = card_rx_valid_i && card_rx_ready_o;

  assign card_tx_valid_o = busy && dir_q && owed && (tx_cnt != '0);
  assign card_tx_data_o  = tx_head;
  assign tx_pop          = card_tx_valid_o && card_tx_ready_i;

  assign byte_done = rx_push || tx_pop;
  assign busy_o    = busy;

  blkx_rx_fifo #(.DEPTH(RX_DEPTH), .LANES(LANES)) u_rx (
    .clk         (clk),
    .rst_n       (rst_ni),
    .clr_i       (start_i),
    .push_i      (rx_push),
    .push_byte_i (card_rx_data_i),
    .pop_i       (rd_pop_i),
    .pop_n_i     (acc_n),
    .rd_data_o   (rd_data_o),
    .cnt_o       (rx_cnt)
  );

  blkx_tx_fifo #(.HALF(TX_HALF), .LANES(LANES)) u_tx (
    .clk         (clk),
    .rst_n       (rst_ni),
    .clr_i       (start_i),
    .flush_i     (flush_i),
    .push_i      (wr_push_i),
    .push_n_i    (acc_n),
    .push_data_i (wr_data_i),
    .pop_i       (tx_pop),
    .head_o      (tx_head),
    .cnt_o       (tx_cnt)
  );

  blkx_xfer_ctrl #(.LEN_W(LEN_W), .NUM_W(NUM_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_ni),
    .start_i        (start_i),
    .dir_i          (dir_wr_i),
    .blk_len_i      (blk_len_i),
    .blk_num_i      (blk_cnt_i),
    .stop_i         (clk_stop_i),
    .byte_done_i    (byte_done),
    .rx_got_i       (rx_push),
    .rx_read_i      (rd_pop_i),
    .tx_write_i     (wr_push_i),
    .tx_empty_i     (tx_cnt == '0),
    .ev_ack_i       (ev_ack_i),
    .busy_o         (busy),
    .dir_o          (dir_q),
    .remain_o       (remain_o),
    .ev_rx_svc_o    (ev_rx_svc_o),
    .ev_tx_svc_o    (ev_tx_svc_o),
    .ev_data_done_o (ev_data_done_o),
    .ev_prog_done_o (ev_prog_done_o),
    .st_data_done_o (st_data_done_o),
    .st_prog_done_o (st_prog_done_o)
  );

  // R2: card bytes are never taken outside a read phase
  p_rx_only_read_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_push |-> (busy && !dir_q));

  // R6: card bytes are never offered outside a write phase
  p_tx_only_write_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_pop |-> (busy && dir_q));

endmodule

// File: tb/test_blk_xfer_engine.sv
`timescale 1ns/1ps
module test_blk_xfer_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, dir_wr_i, clk_stop_i, rd_pop_i, wr_push_i, flush_i;
  logic [11:0] blk_len_i;
  logic [15:0] blk_cnt_i;
  logic [1:0]  acc_size_i, ev_ack_i;
  logic [31:0] rd_data_o, wr_data_i;
  logic        card_rx_valid_i, card_rx_ready_o;
  logic [7:0]  card_rx_data_i, card_tx_data_o;
  logic        card_tx_valid_o, card_tx_ready_i;
  logic        busy_o;
  logic [27:0] remain_o;
  logic        ev_rx_svc_o, ev_tx_svc_o, ev_data_done_o, ev_prog_done_o;
  logic        st_data_done_o, st_prog_done_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  blk_xfer_engine i_blk_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_wr_i(dir_wr_i),
    .blk_len_i(blk_len_i), .blk_cnt_i(blk_cnt_i), .clk_stop_i(clk_stop_i),
    .acc_size_i(acc_size_i), .rd_pop_i(rd_pop_i), .rd_data_o(rd_data_o),
    .wr_push_i(wr_push_i), .wr_data_i(wr_data_i), .flush_i(flush_i),
    .ev_ack_i(ev_ack_i), .card_rx_valid_i(card_rx_valid_i),
    .card_rx_data_i(card_rx_data_i), .card_rx_ready_o(card_rx_ready_o),
    .card_tx_valid_o(card_tx_valid_o), .card_tx_data_o(card_tx_data_o),
    .card_tx_ready_i(card_tx_ready_i), .busy_o(busy_o), .remain_o(remain_o),
    .ev_rx_svc_o(ev_rx_svc_o), .ev_tx_svc_o(ev_tx_svc_o),
    .ev_data_done_o(ev_data_done_o), .ev_prog_done_o(ev_prog_done_o),
    .st_data_done_o(st_data_done_o), .st_prog_done_o(st_prog_done_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start(input logic [11:0] len, input logic [15:0] num, input logic dir);
    start_i = 1'b1; blk_len_i = len; blk_cnt_i = num; dir_wr_i = dir;
    step();
    start_i = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] sz, input logic [31:0] exp, input string req);
    rd_pop_i = 1'b1; acc_size_i = sz;
    #1 chk(req, "receive word", rd_data_o, exp);
    step();
    rd_pop_i = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] sz, input logic [31:0] d);
    wr_push_i = 1'b1; acc_size_i = sz; wr_data_i = d;
    step();
    wr_push_i = 1'b0;
  endtask

  task automatic do_stop();
    clk_stop_i = 1'b1;
    step();
    clk_stop_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "busy after reset", 32'(busy_o), 32'd0);
    chk("R1", "remain after reset", 32'(remain_o), 32'd0);
    chk("R3", "events after reset",
        {28'd0, ev_rx_svc_o, ev_tx_svc_o, ev_data_done_o, ev_prog_done_o}, 32'd0);
    chk("R2", "rx ready after reset", 32'(card_rx_ready_o), 32'd0);
    chk("R6", "tx valid after reset", 32'(card_tx_valid_o), 32'd0);
    chk("R4", "rx data empty", rd_data_o, 32'd0);
  endtask

  task automatic t_rx_basic();
    do_start(12'd3, 16'd2, 1'b0);
    chk("R1", "remain loaded", 32'(remain_o), 32'd6);
    chk("R1", "busy after start", 32'(busy_o), 32'd1);
    card_rx_valid_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      card_rx_data_i = 8'hA0 + 8'(i);
      #1 chk("R2", "rx ready while owed", 32'(card_rx_ready_o), 32'd1);
      step();
      if (i == 0) chk("R3", "rx service set", 32'(ev_rx_svc_o), 32'd1);
      chk("R3", "remain counts down", 32'(remain_o), 32'(5 - i));
    end
    #1 chk("R2", "rx ready at zero", 32'(card_rx_ready_o), 32'd0);
    card_rx_valid_i = 1'b0;
    step();
    chk("R7", "busy after done", 32'(busy_o), 32'd0);
    chk("R7", "data done status", 32'(st_data_done_o), 32'd1);
    chk("R7", "data done event", 32'(ev_data_done_o), 32'd1);
    chk("R7", "no program done on read", 32'(st_prog_done_o), 32'd0);
    do_read(2'd2, 32'hA0A1A2A3, "R4");
    chk("R4", "rx service cleared", 32'(ev_rx_svc_o), 32'd0);
    do_read(2'd0, 32'h000000A4, "R11");
    do_read(2'd1, 32'h0000A500, "R4");
    do_read(2'd3, 32'h00000000, "R4");
    ev_ack_i = 2'b01;
    step();
    ev_ack_i = 2'b00;
    chk("R12", "data done event acked", 32'(ev_data_done_o), 32'd0);
    chk("R12", "data done status kept", 32'(st_data_done_o), 32'd1);
  endtask

  task automatic t_rx_full_abort();
    int taken = 0;
    do_start(12'd40, 16'd1, 1'b0);
    chk("R12", "status cleared by start", 32'(st_data_done_o), 32'd0);
    card_rx_valid_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      card_rx_data_i = 8'(i);
      #1 if (card_rx_ready_o) taken++;
      step();
    end
    card_rx_valid_i = 1'b0;
    chk("R2", "bytes held when full", 32'(taken), 32'd32);
    chk("R2", "remain when full", 32'(remain_o), 32'd8);
    #1 chk("R2", "rx ready when full", 32'(card_rx_ready_o), 32'd0);
    do_read(2'd2, 32'h00010203, "R4");
    #1 chk("R2", "rx ready after pop", 32'(card_rx_ready_o), 32'd1);
    do_stop();
    chk("R9", "busy after stop", 32'(busy_o), 32'd0);
    chk("R9", "no data done on abort", 32'(st_data_done_o), 32'd0);
  endtask

  task automatic t_tx_basic();
    logic [7:0] exp_b [5];
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h33; exp_b[3] = 8'h44; exp_b[4] = 8'h55;
    card_tx_ready_i = 1'b0;
    do_start(12'd5, 16'd1, 1'b1);
    step();
    chk("R6", "tx service when empty", 32'(ev_tx_svc_o), 32'd1);
    do_write(2'd2, 32'h11223344);
    chk("R5", "tx service cleared by write", 32'(ev_tx_svc_o), 32'd0);
    do_write(2'd0, 32'h00000055);
    card_tx_ready_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R6", "tx valid", 32'(card_tx_valid_o), 32'd1);
      chk("R5", "tx byte order", 32'(card_tx_data_o), 32'(exp_b[i]));
      step();
    end
    #1 chk("R6", "tx idle at zero", 32'(card_tx_valid_o), 32'd0);
    step();
    card_tx_ready_i = 1'b0;
    chk("R7", "busy after write done", 32'(busy_o), 32'd0);
    chk("R7", "program done status", 32'(st_prog_done_o), 32'd1);
    chk("R7", "program done event", 32'(ev_prog_done_o), 32'd1);
    chk("R7", "data done on write", 32'(st_data_done_o), 32'd1);
    ev_ack_i = 2'b11;
    step();
    ev_ack_i = 2'b00;
    chk("R12", "program done event acked", 32'(ev_prog_done_o), 32'd0);
  endtask

  task automatic t_tx_cap();
    card_tx_ready_i = 1'b0;
    do_start(12'd40, 16'd1, 1'b1);
    for (int k = 0; k < 9; k++) begin
      do_write(2'd3, {8'(8'h40 + 4*k), 8'(8'h41 + 4*k), 8'(8'h42 + 4*k), 8'(8'h43 + 4*k)});
    end
    card_tx_ready_i = 1'b1;
    for (int i = 0; i < 32; i++) begin
      #1 chk("R5", "capped tx byte", {card_tx_valid_o, 23'd0, card_tx_data_o},
             {1'b1, 23'd0, 8'(8'h40 + i)});
      step();
    end
    #1 chk("R5", "ninth word dropped", 32'(card_tx_valid_o), 32'd0);
    chk("R6", "remain after 32 bytes", 32'(remain_o), 32'd8);
    step();
    chk("R6", "tx service after drain", 32'(ev_tx_svc_o), 32'd1);
    card_tx_ready_i = 1'b0;
    do_stop();
  endtask

  task automatic t_flush();
    card_tx_ready_i = 1'b0;
    do_start(12'd4, 16'd1, 1'b1);
    do_write(2'd2, 32'hDEADBEEF);
    flush_i = 1'b1;
    step();
    flush_i = 1'b0;
    dir_wr_i = 1'b0;
    do_write(2'd1, 32'h00007A7B);
    card_tx_ready_i = 1'b1;
    #1 chk("R8", "first byte after flush", {card_tx_valid_o, 23'd0, card_tx_data_o},
           {1'b1, 23'd0, 8'h7A});
    step();
    #1 chk("R10", "direction held", {card_tx_valid_o, 23'd0, card_tx_data_o},
           {1'b1, 23'd0, 8'h7B});
    step();
    #1 chk("R8", "flushed bytes gone", 32'(card_tx_valid_o), 32'd0);
    chk("R8", "remain after flush", 32'(remain_o), 32'd2);
    chk("R10", "rx ready stays low", 32'(card_rx_ready_o), 32'd0);
    card_tx_ready_i = 1'b0;
    do_stop();
  endtask

  task automatic t_zero_len();
    do_start(12'd7, 16'd0, 1'b0);
    chk("R1", "zero product", 32'(remain_o), 32'd0);
    step();
    chk("R7", "zero length ends", 32'(busy_o), 32'd0);
    chk("R7", "zero length done", 32'(st_data_done_o), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 0; dir_wr_i = 0; clk_stop_i = 0; rd_pop_i = 0; wr_push_i = 0; flush_i = 0;
    blk_len_i = '0; blk_cnt_i = '0; acc_size_i = '0; ev_ack_i = '0; wr_data_i = '0;
    card_rx_valid_i = 0; card_rx_data_i = '0; card_tx_ready_i = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_rx_basic();
    t_rx_full_abort();
    t_tx_basic();
    t_tx_cap();
    t_flush();
    t_zero_len();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule